// File: doc/BRIEF.md
# Comparator Event and Interrupt Logic

This block is the digital back end for a bank of analog voltage comparators. For each comparator it forwards the input-select codes to the analog macro, takes the macro's raw result bit, and applies an optional polarity inversion. The adjusted, unsynchronized result can be driven straight to a pad. The same adjusted result is brought into the clock domain through a flop chain and exposed as a status bit for software.

The synchronized result feeds an edge detector. A two-bit code per comparator chooses rising, falling, either or no edges. A detected edge sets a sticky flag whether or not its interrupt is unmasked. The interrupt request is the flag qualified by a per-comparator enable, and software clears the flag with a one-cycle clear strobe. Two global controls gate the whole bank. One stops all comparators while the device idles. The other freezes all state while the CPU is halted for debug.

All pins are plain control and status levels. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `cmp_event_ctrl`

## Requirements
- R1: `pos_sel_o[i]` follows `pos_sel_i[i]` (0 = own positive pin, 1 = adjustable internal reference). `neg_sel_o[i]` follows `neg_sel_i[i]` (00 = own negative pin, 01 = own positive pin, 10 = other comparator's positive pin, 11 = fixed internal reference).
- R2: After reset, `status_o`, `flag_o` and `irq_o` are all 0.
- R3: While comparator i runs, `status_o[i]` equals `raw_i[i] ^ invert_i[i]` delayed by exactly two clock edges.
- R4: `edge_sel_i[i]` selects the events that set the flag: 00 none, 01 a 0-to-1 change of the synchronized adjusted result, 10 a 1-to-0 change, 11 either change.
- R5: With `invert_i[i]` = 1, the pad, the status bit and the edge detector all see the inverted result. A 0-to-1 change of `raw_i` is then a falling event.
- R6: `pad_drv_o[i]` is 1 only when `pad_oe_i[i]` is 1 and the comparator runs. While it is 1, `pad_out_o[i]` is the unsynchronized `raw_i[i] ^ invert_i[i]`; otherwise `pad_out_o[i]` is 0.
- R7: A detected event sets `flag_o[i]` whatever `irq_en_i[i]` is. `irq_o[i]` = `flag_o[i]` & `irq_en_i[i]`. The flag stays 1 until `flag_clr_i[i]` is high at a clock edge, and an event in that same cycle keeps it set.
- R8: With `en_i[i]` = 0, the comparator is off and `status_o[i]` and its edge history are held at 0. The flag keeps its value and can still be cleared. Enabling while the adjusted input is 0 raises no event.
- R9: While `frz_en_i` and `dbg_halt_i` are both 1, no state changes: the synchronizer, edge history and flag hold, and a clear strobe is ignored. Operation resumes when `dbg_halt_i` falls.
- R10: While `idle_stop_i` and `idle_mode_i` are both 1, every comparator is off as in R8. With `idle_stop_i` = 0, idle mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | NCMP | Per-comparator enable |
| invert_i | input | NCMP | Output polarity inversion |
| pad_oe_i | input | NCMP | Pad output request |
| pos_sel_i | input | NCMP | Positive-input select code |
| neg_sel_i | input | 2*NCMP | Negative-input select code, two bits per comparator |
| edge_sel_i | input | 2*NCMP | Event edge code, two bits per comparator |
| irq_en_i | input | NCMP | Interrupt mask, 1 = unmasked |
| flag_clr_i | input | NCMP | Flag clear strobe |
| idle_stop_i | input | 1 | Stop all comparators in idle mode |
| idle_mode_i | input | 1 | Device is in idle mode |
| frz_en_i | input | 1 | Freeze on debug halt |
| dbg_halt_i | input | 1 | CPU halted in debug |
| raw_i | input | NCMP | Raw result bits from the analog macro |
| pos_sel_o | output | NCMP | Positive-input select to the macro |
| neg_sel_o | output | 2*NCMP | Negative-input select to the macro |
| pad_out_o | output | NCMP | Unsynchronized adjusted result for the pad |
| pad_drv_o | output | NCMP | Pad output enable |
| status_o | output | NCMP | Synchronized adjusted result |
| flag_o | output | NCMP | Sticky event flag |
| irq_o | output | NCMP | Interrupt request |

## Verification
The bench drives every edge code with inversion both off and on. A detector that ignored the inversion would flag the raw edge instead of the adjusted one, and a wrong decode would flag the wrong direction. It re-enables a comparator whose history was 1 before it was disabled, with the input now low. A design that held the history instead of zeroing it would raise a false falling event. It also strobes clear during a debug freeze and pulses an event under a closed mask. A design that let the freeze leak would lose the flag, and one that gated the flag with the mask would never set it.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/cmp_sync.sv
// Flop chain bringing the asynchronous comparator result into the clock domain.
// hold freezes the chain; zero forces every stage to 0.
module cmp_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic zero,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stage <= '0;
    else if (hold)  stage <= stage;
    else if (zero)  stage <= '0;
    else            stage <= {stage[DEPTH-2:0], d};
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/cmp_edge_flag.sv
// Edge detector on the synchronized sample plus the sticky event flag.
module cmp_edge_flag
  import cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       zero,
  input  logic       sample,
  input  logic [1:0] edge_sel,
  input  logic       clr,
  output logic       flag
);
  logic prev;
  logic rise, fall, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prev <= 1'b0;
    else if (hold)  prev <= prev;
    else if (zero)  prev <= 1'b0;
    else            prev <= sample;
  end

  assign rise = sample & ~prev;
  assign fall = ~sample & prev;

  always_comb begin
    unique case (edge_sel_e'(edge_sel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    if (zero) hit = 1'b0;
  end

  // An event in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (hold)  flag <= flag;
    else            flag <= (flag & ~clr) | hit;
  end
endmodule

// File: rtl/cmp_channel.sv
// One comparator's digital path: polarity, pad drive, synchronizer, event flag.
module cmp_channel #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       freeze,
  input  logic       invert,
  input  logic       pad_oe,
  input  logic [1:0] edge_sel,
  input  logic       irq_en,
  input  logic       flag_clr,
  input  logic       raw,
  output logic       pad_out,
  output logic       pad_drv,
  output logic       status,
  output logic       flag,
  output logic       irq
);
  logic adj;

  assign adj     = raw ^ invert;
  assign pad_drv = pad_oe & active;
  assign pad_out = pad_drv & adj;

  cmp_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (freeze),
    .zero (~active),
    .d    (adj),
    .q    (status)
  );

  cmp_edge_flag u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (freeze),
    .zero    (~active),
    .sample  (status),
    .edge_sel(edge_sel),
    .clr     (flag_clr),
    .flag    (flag)
  );

  assign irq = flag & irq_en;
endmodule

// File: rtl/cmp_event_ctrl.sv
module cmp_event_ctrl #(
  parameter int NCMP       = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCMP-1:0]      en_i,
  input  logic [NCMP-1:0]      invert_i,
  input  logic [NCMP-1:0]      pad_oe_i,
  input  logic [NCMP-1:0]      pos_sel_i,
  input  logic [NCMP-1:0][1:0] neg_sel_i,
  input  logic [NCMP-1:0][1:0] edge_sel_i,
  input  logic [NCMP-1:0]      irq_en_i,
  input  logic [NCMP-1:0]      flag_clr_i,
  input  logic                 idle_stop_i,
  input  logic                 idle_mode_i,
  input  logic                 frz_en_i,
  input  logic                 dbg_halt_i,
  input  logic [NCMP-1:0]      raw_i,
  output logic [NCMP-1:0]      pos_sel_o,
  output logic [NCMP-1:0][1:0] neg_sel_o,
  output logic [NCMP-1:0]      pad_out_o,
  output logic [NCMP-1:0]      pad_drv_o,
  output logic [NCMP-1:0]      status_o,
  output logic [NCMP-1:0]      flag_o,
  output logic [NCMP-1:0]      irq_o
);
  logic freeze;
  logic idle_off;

  assign freeze   = frz_en_i & dbg_halt_i;
  assign idle_off = idle_stop_i & idle_mode_i;

  assign pos_sel_o = pos_sel_i;
  assign neg_sel_o = neg_sel_i;

  for (genvar i = 0; i < NCMP; i++) begin : g_ch
    cmp_channel #(.SYNC_DEPTH(SYNC_DEPTH)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (en_i[i] & ~idle_off),
      .freeze  (freeze),
      .invert  (invert_i[i]),
      .pad_oe  (pad_oe_i[i]),
      .edge_sel(edge_sel_i[i]),
      .irq_en  (irq_en_i[i]),
      .flag_clr(flag_clr_i[i]),
      .raw     (raw_i[i]),
      .pad_out (pad_out_o[i]),
      .pad_drv (pad_drv_o[i]),
      .status  (status_o[i]),
      .flag    (flag_o[i]),
      .irq     (irq_o[i])
    );
  end
endmodule

// File: rtl/cmp_event_ctrl_chk.sv
module cmp_event_ctrl_chk #(
  parameter int NCMP = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCMP-1:0]      en_i,
  input logic [NCMP-1:0][1:0] edge_sel_i,
  input logic [NCMP-1:0]      irq_en_i,
  input logic [NCMP-1:0]      flag_clr_i,
  input logic                 idle_stop_i,
  input logic                 idle_mode_i,
  input logic                 frz_en_i,
  input logic                 dbg_halt_i,
  input logic [NCMP-1:0]      pad_out_o,
  input logic [NCMP-1:0]      pad_drv_o,
  input logic [NCMP-1:0]      status_o,
  input logic [NCMP-1:0]      flag_o,
  input logic [NCMP-1:0]      irq_o
);
  for (genvar i = 0; i < NCMP; i++) begin : g_a
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[i] && !flag_clr_i[i]) |=> flag_o[i]); // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[i] |-> (flag_o[i] && irq_en_i[i])); // R7
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_en_i && dbg_halt_i) |=> ($stable(flag_o[i]) && $stable(status_o[i]))); // R9
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i[i] && !(frz_en_i && dbg_halt_i)) |=> !status_o[i]); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_stop_i && idle_mode_i && !(frz_en_i && dbg_halt_i)) |=> !status_o[i]); // R10
    AST_NO_EVENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o[i] && edge_sel_i[i] == 2'b00) |=> !flag_o[i]); // R4
    AST_PAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_drv_o[i] |-> !pad_out_o[i]); // R6
  end
endmodule

bind cmp_event_ctrl cmp_event_ctrl_chk #(.NCMP(NCMP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .edge_sel_i (edge_sel_i),
  .irq_en_i   (irq_en_i),
  .flag_clr_i (flag_clr_i),
  .idle_stop_i(idle_stop_i),
  .idle_mode_i(idle_mode_i),
  .frz_en_i   (frz_en_i),
  .dbg_halt_i (dbg_halt_i),
  .pad_out_o  (pad_out_o),
  .pad_drv_o  (pad_drv_o),
  .status_o   (status_o),
  .flag_o     (flag_o),
  .irq_o      (irq_o)
);

// File: tb/tb_cmp_event_ctrl.sv
`timescale 1ns/1ps
module tb_cmp_event_ctrl;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]      en = '0, invert = '0, pad_oe = '0, pos_sel = '0;
  logic [N-1:0][1:0] neg_sel = '0, edge_sel = '0;
  logic [N-1:0]      irq_en = '0, flag_clr = '0, raw = '0;
  logic idle_stop = 1'b0, idle_mode = 1'b0, frz_en = 1'b0, dbg_halt = 1'b0;
  logic [N-1:0]      pos_sel_o, pad_out, pad_drv, status, flag, irq;
  logic [N-1:0][1:0] neg_sel_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_event_ctrl #(.NCMP(N)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .invert_i(invert), .pad_oe_i(pad_oe),
    .pos_sel_i(pos_sel), .neg_sel_i(neg_sel), .edge_sel_i(edge_sel),
    .irq_en_i(irq_en), .flag_clr_i(flag_clr), .idle_stop_i(idle_stop),
    .idle_mode_i(idle_mode), .frz_en_i(frz_en), .dbg_halt_i(dbg_halt),
    .raw_i(raw), .pos_sel_o(pos_sel_o), .neg_sel_o(neg_sel_o),
    .pad_out_o(pad_out), .pad_drv_o(pad_drv), .status_o(status),
    .flag_o(flag), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clr(input int ch);
    flag_clr[ch] = 1'b1;
    step(1);
    flag_clr[ch] = 1'b0;
  endtask

  // Bring channel 0 to a known running state with a cleared flag.
  task automatic settle0(input logic inv, input logic [1:0] code, input logic r);
    en[0] = 1'b1; invert[0] = inv; edge_sel[0] = code; raw[0] = r;
    step(4);
    pulse_clr(0);
  endtask

  task automatic t_reset();
    check("R2 status after reset", status, 0);
    check("R2 flag after reset", flag, 0);
    check("R2 irq after reset", irq, 0);
  endtask

  task automatic t_select();
    pos_sel = 2'b10; neg_sel[0] = 2'b11; neg_sel[1] = 2'b10;
    #1;
    check("R1 pos select", pos_sel_o, 2'b10);
    check("R1 neg select ch0", neg_sel_o[0], 2'b11);
    check("R1 neg select ch1", neg_sel_o[1], 2'b10);
    pos_sel = 2'b01; neg_sel[0] = 2'b01; neg_sel[1] = 2'b00;
    #1;
    check("R1 pos select swap", pos_sel_o, 2'b01);
    check("R1 neg select ch0 b", neg_sel_o[0], 2'b01);
    check("R1 neg select ch1 b", neg_sel_o[1], 2'b00);
  endtask

  task automatic t_latency();
    settle0(1'b0, 2'b00, 1'b0);
    raw[0] = 1'b1;
    step(1);
    check("R3 status one edge after change", status[0], 0);
    step(1);
    check("R3 status two edges after change", status[0], 1);
    invert[0] = 1'b1;
    step(2);
    check("R3 status with inversion", status[0], 0);
    invert[0] = 1'b0; raw[0] = 1'b0;
    step(3);
  endtask

  task automatic t_edge(input logic inv, input logic [1:0] code);
    logic e_up, e_dn;
    e_up = (code == 2'b11) || (code == 2'b01 && !inv) || (code == 2'b10 && inv);
    e_dn = (code == 2'b11) || (code == 2'b10 && !inv) || (code == 2'b01 && inv);
    settle0(inv, code, 1'b0);
    check(inv ? "R5 flag clear before raw rise" : "R4 flag clear before raw rise", flag[0], 0);
    raw[0] = 1'b1;
    step(3);
    check(inv ? "R5 flag after raw rise, inverted" : "R4 flag after raw rise", flag[0], e_up);
    pulse_clr(0);
    step(1);
    raw[0] = 1'b0;
    step(3);
    check(inv ? "R5 flag after raw fall, inverted" : "R4 flag after raw fall", flag[0], e_dn);
    edge_sel[0] = 2'b00;
    pulse_clr(0);
  endtask

  task automatic t_pad();
    en[0] = 1'b1; pad_oe[0] = 1'b1; invert[0] = 1'b0; raw[0] = 1'b1;
    #1;
    check("R6 pad drives raw at once", pad_out[0], 1);
    check("R6 pad enable", pad_drv[0], 1);
    invert[0] = 1'b1;
    #1;
    check("R5 pad inverted", pad_out[0], 0);
    invert[0] = 1'b0; pad_oe[0] = 1'b0;
    #1;
    check("R6 pad quiet without request", pad_out[0], 0);
    check("R6 pad enable off", pad_drv[0], 0);
    pad_oe[0] = 1'b1; en[0] = 1'b0;
    #1;
    check("R6 pad quiet when disabled", pad_drv[0], 0);
    pad_oe[0] = 1'b0; en[0] = 1'b1; raw[0] = 1'b0;
    step(4);
  endtask

  task automatic t_mask();
    settle0(1'b0, 2'b01, 1'b0);
    irq_en[0] = 1'b0;
    raw[0] = 1'b1;
    step(3);
    check("R7 flag set under closed mask", flag[0], 1);
    check("R7 irq held off by mask", irq[0], 0);
    irq_en[0] = 1'b1;
    #1;
    check("R7 irq once unmasked", irq[0], 1);
    step(5);
    check("R7 flag sticky", flag[0], 1);
    pulse_clr(0);
    check("R7 flag cleared by strobe", flag[0], 0);
    check("R7 irq drops with flag", irq[0], 0);
    irq_en[0] = 1'b0; raw[0] = 1'b0; edge_sel[0] = 2'b00;
    step(3);
  endtask

  task automatic t_channel1();
    settle0(1'b0, 2'b00, 1'b0);
    en[1] = 1'b1; edge_sel[1] = 2'b01; raw[1] = 1'b0;
    step(4);
    pulse_clr(1);
    raw[1] = 1'b1;
    step(3);
    check("R4 ch1 rise sets ch1 flag", flag[1], 1);
    check("R4 ch1 event leaves ch0 flag", flag[0], 0);
    raw[1] = 1'b0; edge_sel[1] = 2'b00; en[1] = 1'b0;
    step(3);
    pulse_clr(1);
  endtask

  task automatic t_disable();
    settle0(1'b0, 2'b11, 1'b0);
    raw[0] = 1'b1;
    step(3);
    check("R8 setup flag", flag[0], 1);
    en[0] = 1'b0;
    step(3);
    check("R8 status zero when off", status[0], 0);
    check("R8 flag kept when off", flag[0], 1);
    pulse_clr(0);
    check("R8 clear works when off", flag[0], 0);
    raw[0] = 1'b0; edge_sel[0] = 2'b10;
    step(2);
    en[0] = 1'b1;
    step(5);
    check("R8 no false fall on enable", flag[0], 0);
    edge_sel[0] = 2'b00;
  endtask

  task automatic t_freeze();
    settle0(1'b0, 2'b11, 1'b0);
    frz_en = 1'b1; dbg_halt = 1'b1;
    raw[0] = 1'b1;
    step(6);
    check("R9 status frozen", status[0], 0);
    check("R9 flag frozen", flag[0], 0);
    dbg_halt = 1'b0;
    step(3);
    check("R9 event after resume", flag[0], 1);
    check("R9 status after resume", status[0], 1);
    dbg_halt = 1'b1;
    pulse_clr(0);
    step(1);
    check("R9 clear ignored while frozen", flag[0], 1);
    dbg_halt = 1'b0; frz_en = 1'b0;
    pulse_clr(0);
    check("R9 clear after resume", flag[0], 0);
    frz_en = 1'b0; dbg_halt = 1'b1;
    raw[0] = 1'b0;
    step(3);
    check("R9 halt without freeze keeps running", flag[0], 1);
    dbg_halt = 1'b0;
    edge_sel[0] = 2'b00;
    pulse_clr(0);
  endtask

  task automatic t_idle();
    settle0(1'b0, 2'b11, 1'b0);
    idle_stop = 1'b1; idle_mode = 1'b1;
    raw[0] = 1'b1;
    step(4);
    check("R10 status off in stopped idle", status[0], 0);
    check("R10 no event in stopped idle", flag[0], 0);
    idle_stop = 1'b0;
    step(3);
    check("R10 idle without stop runs", status[0], 1);
    check("R10 idle without stop raises event", flag[0], 1);
    idle_mode = 1'b0;
    raw[0] = 1'b0; edge_sel[0] = 2'b00;
    step(3);
    pulse_clr(0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_select();
    t_latency();
    for (int inv = 0; inv < 2; inv++)
      for (int c = 0; c < 4; c++)
        t_edge(inv[0], c[1:0]);
    t_pad();
    t_mask();
    t_channel1();
    t_disable();
    t_freeze();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule